// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral on a small synchronous register port. A prescaler divides the system clock into a slow tick. A 10-bit down-counter is decremented on each tick and starts again from a programmable initial value. Software services the watchdog by writing to a reload register. A sticky flag set by the first missed service tells software that the time ran out once. When the SMI enable is set, that first expiry also gives a one-cycle interrupt pulse.

If the count runs out a second time while the first-stage flag is still set, a second-stage flag is set. A reset-request pulse of fixed length then goes out, unless the no-reboot gate is closed. Software restarts the two-expiry sequence by clearing the first-stage flag and reloading. The counter leaves reset halted and with the no-reboot gate closed, so nothing happens until software arms it.

Register map (word addresses on `bus_addr`):
- 0: reload. A write of any data forces the count to the initial value. A read returns the live count in bits 9:0.
- 1: initial value.
- 2: first-stage status.
- 3: second-stage status.
- 4: control.
- 5: SMI control.

`bus_be[0]` enables bits 7:0 of a write and `bus_be[1]` enables bits 15:8.

Top module: `two_stage_wdt`

## Requirements
- R1: While the counter runs, the prescaler gives one tick every TICK_CLKS clocks. An expiry occurs on the tick that takes the count from 1 to its end; at that tick the count is reloaded from the initial value. A first-stage expiry therefore follows a reload write, or the clearing of the halt bit, after exactly init×TICK_CLKS clock edges.
- R2: The initial-value register (address 1) holds the reload count in bits 9:0. Bits 15:10 are stored and read back unchanged. Each byte is written only when its enable in `bus_be` is set.
- R3: A write to address 1 whose merged bits 9:0 are below 4 is ignored. The register keeps its previous contents.
- R4: A write of any data to address 0 sets the count to the initial value and restarts the prescaler. A read of address 0 returns the current count in bits 9:0, which falls by one per tick.
- R5: Control bit 11 is a halt bit, and it is 1 after reset. While it is 1, the count does not change except through a reload write, and no expiry occurs.
- R6: The first expiry sets bit 3 of address 2. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R7: An expiry while bit 3 of address 2 is set sets bit 1 of address 3 and starts a reset request. Clearing bit 3 of address 2 and reloading makes the next expiry a first-stage one again.
- R8: Bit 2 of address 3 is a boot flag, and it is 1 after reset. Bits 1 and 2 of address 3 are both write-one-to-clear.
- R9: Control bit 0 is the no-reboot gate, and it is 1 after reset. It reads back as written. While it is 1, a second-stage expiry sets the status bit but gives no pulse on `rst_req`.
- R10: A reset request is a single `rst_req` pulse of exactly RST_PULSE clock cycles. It starts on the cycle after the expiry.
- R11: Bit 13 of address 5 enables the SMI. A first-stage expiry with that bit set gives a `smi_req` pulse of exactly one cycle, on the cycle after the expiry. With the bit clear, no pulse is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte write enables, bit 0 for bits 7:0 |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 16 | Read data, zero when `bus_rd` is low |
| smi_req | output | 1 | One-cycle first-stage interrupt request |
| rst_req | output | 1 | Second-stage reset request pulse |

## Verification
A fault in the prescaler or the down-counter shows up as an expiry pulse off its expected cycle. The first such pulse comes init×TICK_CLKS edges after the reload, so timing errors appear within one timeout period and can be told apart to the clock edge. A wrong stage flag shows as the wrong kind of pulse: a reset where an SMI was due, or the reverse. It also shows at once when the status registers are read back. A stored initial value that was corrupted, for example by an invalid write, gives a wrong read of address 1 at once, and a shifted expiry time on the next run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 10;

    typedef enum logic [ADDR_W-1:0] {
        A_RELOAD = 3'd0,
        A_INIT   = 3'd1,
        A_STAT1  = 3'd2,
        A_STAT2  = 3'd3,
        A_CTRL   = 3'd4,
        A_SMI    = 3'd5
    } wdt_addr_e;

    localparam int HALT_BIT     = 11;
    localparam int NOREBOOT_BIT = 0;
    localparam int TO1_BIT      = 3;
    localparam int TO2_BIT      = 1;
    localparam int BOOT_BIT     = 2;
    localparam int SMIEN_BIT    = 13;

    localparam logic [CNT_W-1:0] MIN_INIT = CNT_W'(4);

    typedef struct packed {
        logic reload;
        logic clr_to1;
        logic clr_to2;
        logic clr_boot;
    } wdt_cmd_t;

    typedef struct packed {
        logic to1;
        logic to2;
        logic boot;
    } wdt_flags_t;

    function automatic logic [DATA_W-1:0] merge_bytes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [1:0]        be
    );
        return {be[1] ? new_v[15:8] : old_v[15:8],
                be[0] ? new_v[7:0]  : old_v[7:0]};
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int TICK_CLKS = 75_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);

    logic [PW-1:0] pcnt;

    assign tick = run && (pcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PW'(1);
        end
    end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int                         CNT_W      = 10,
    parameter logic [CNT_W-1:0]           INIT_RESET = 10'd50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = tick && !reload && (cnt <= ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= INIT_RESET;
        end else if (reload || expire) begin
            cnt <= init_val;
        end else if (tick) begin
            cnt <= cnt - ONE;
        end
    end
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage
    import wdt_pkg::*;
#(
    parameter int RST_PULSE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       expire,
    input  logic       noreboot,
    input  logic       smi_en,
    input  wdt_cmd_t   cmd,
    output wdt_flags_t flags,
    output logic       smi_req,
    output logic       rst_req
);
    localparam int RW = $clog2(RST_PULSE + 1);

    logic [RW-1:0] rst_cnt;
    logic          first_hit;
    logic          second_hit;

    assign first_hit  = expire && !flags.to1;
    assign second_hit = expire && flags.to1;
    assign rst_req    = (rst_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags.to1  <= 1'b0;
            flags.to2  <= 1'b0;
            flags.boot <= 1'b1;
            smi_req    <= 1'b0;
            rst_cnt    <= '0;
        end else begin
            if (first_hit)        flags.to1 <= 1'b1;
            else if (cmd.clr_to1) flags.to1 <= 1'b0;

            if (second_hit)       flags.to2 <= 1'b1;
            else if (cmd.clr_to2) flags.to2 <= 1'b0;

            if (cmd.clr_boot)     flags.boot <= 1'b0;

            smi_req <= first_hit && smi_en;

            if (second_hit && !noreboot) rst_cnt <= RW'(RST_PULSE);
            else if (rst_cnt != '0)      rst_cnt <= rst_cnt - RW'(1);
        end
    end
endmodule

// File: rtl/two_stage_wdt.sv
module two_stage_wdt
    import wdt_pkg::*;
#(
    parameter int                 TICK_CLKS  = 75_000_000,
    parameter int                 RST_PULSE  = 16,
    parameter logic [CNT_W-1:0]   INIT_RESET = 10'd50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        bus_be,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              smi_req,
    output logic              rst_req
);
    logic [DATA_W-1:0] init_q;
    logic [DATA_W-1:0] init_next;
    logic              halt_q;
    logic              noreboot_q;
    logic              smi_en_q;
    logic [CNT_W-1:0]  cnt;
    logic              tick;
    logic              expire;
    logic              reload_wr;
    logic              sec_to_q;
    wdt_cmd_t          cmd;
    wdt_flags_t        flags;

    function automatic logic hit(input wdt_addr_e a);
        return bus_wr && (bus_addr == a) && (bus_be != 2'b00);
    endfunction

    assign init_next = merge_bytes(init_q, bus_wdata, bus_be);
    assign reload_wr = hit(A_RELOAD);

    always_comb begin
        cmd          = '0;
        cmd.reload   = reload_wr;
        cmd.clr_to1  = hit(A_STAT1) && bus_be[0] && bus_wdata[TO1_BIT];
        cmd.clr_to2  = hit(A_STAT2) && bus_be[0] && bus_wdata[TO2_BIT];
        cmd.clr_boot = hit(A_STAT2) && bus_be[0] && bus_wdata[BOOT_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            init_q     <= {{(DATA_W-CNT_W){1'b0}}, INIT_RESET};
            halt_q     <= 1'b1;
            noreboot_q <= 1'b1;
            smi_en_q   <= 1'b0;
        end else begin
            if (hit(A_INIT) && (init_next[CNT_W-1:0] >= MIN_INIT))
                init_q <= init_next;
            if (hit(A_CTRL) && bus_be[HALT_BIT/8])
                halt_q <= bus_wdata[HALT_BIT];
            if (hit(A_CTRL) && bus_be[NOREBOOT_BIT/8])
                noreboot_q <= bus_wdata[NOREBOOT_BIT];
            if (hit(A_SMI) && bus_be[SMIEN_BIT/8])
                smi_en_q <= bus_wdata[SMIEN_BIT];
        end
    end

    wdt_prescaler #(.TICK_CLKS(TICK_CLKS)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (!halt_q),
        .restart (reload_wr),
        .tick    (tick)
    );

    wdt_countdown #(.CNT_W(CNT_W), .INIT_RESET(INIT_RESET)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .reload   (reload_wr),
        .init_val (init_q[CNT_W-1:0]),
        .cnt      (cnt),
        .expire   (expire)
    );

    wdt_stage #(.RST_PULSE(RST_PULSE)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire),
        .noreboot (noreboot_q),
        .smi_en   (smi_en_q),
        .cmd      (cmd),
        .flags    (flags),
        .smi_req  (smi_req),
        .rst_req  (rst_req)
    );

    assign sec_to_q = flags.to2;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (wdt_addr_e'(bus_addr))
                A_RELOAD: bus_rdata[CNT_W-1:0]   = cnt;
                A_INIT:   bus_rdata              = init_q;
                A_STAT1:  bus_rdata[TO1_BIT]     = flags.to1;
                A_STAT2: begin
                    bus_rdata[TO2_BIT]  = flags.to2;
                    bus_rdata[BOOT_BIT] = flags.boot;
                end
                A_CTRL: begin
                    bus_rdata[HALT_BIT]     = halt_q;
                    bus_rdata[NOREBOOT_BIT] = noreboot_q;
                end
                A_SMI:    bus_rdata[SMIEN_BIT]   = smi_en_q;
                default:  bus_rdata              = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             smi_req,
    input logic             rst_req,
    input logic             halt,
    input logic             noreboot,
    input logic             smi_en,
    input logic             reload_wr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] init_lo,
    input logic             sec_flag
);
    assert_init_valid_R3: assert property (@(posedge clk) disable iff (rst)
        init_lo >= CNT_W'(4));

    assert_halt_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (halt && !reload_wr) |=> $stable(cnt));

    assert_gate_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> !$past(noreboot));

    assert_reset_after_second_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> sec_flag);

    assert_smi_gated_R11: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> $past(smi_en));

    assert_smi_single_R11: assert property (@(posedge clk) disable iff (rst)
        smi_req |=> !smi_req);
endmodule

bind two_stage_wdt wdt_checker #(.CNT_W(wdt_pkg::CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smi_req   (smi_req),
    .rst_req   (rst_req),
    .halt      (halt_q),
    .noreboot  (noreboot_q),
    .smi_en    (smi_en_q),
    .reload_wr (reload_wr),
    .cnt       (cnt),
    .init_lo   (init_q[wdt_pkg::CNT_W-1:0]),
    .sec_flag  (sec_to_q)
);

// File: tb/two_stage_wdt_bench.sv
`timescale 1ns/1ps
module two_stage_wdt_bench;
    localparam int  TICK  = 4;
    localparam int  PULSE = 3;
    localparam longint LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr  = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be    = '0;
    logic        bus_wr    = 1'b0;
    logic        bus_rd    = 1'b0;
    logic [15:0] bus_rdata;
    logic        smi_req;
    logic        rst_req;

    int     checks   = 0;
    int     failures = 0;
    longint cyc      = 0;
    longint last_edge = 0;
    int     rst_rises = 0;

    typedef struct { int kind; longint at; } ev_t;
    ev_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    two_stage_wdt #(.TICK_CLKS(TICK), .RST_PULSE(PULSE), .INIT_RESET(10'd50)) u_two_stage_wdt (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .smi_req(smi_req), .rst_req(rst_req)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(posedge clk);
        #1;
        last_edge = cyc;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_until(input longint c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic push(input int kind, input longint at);
        ev_t e;
        e.kind = kind; e.at = at;
        exp_q.push_back(e);
    endtask

    // Monitor: pops expected events and compares kind, cycle and width
    logic prev_smi = 1'b0, prev_rst = 1'b0;
    int   smi_w = 0, rst_w = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if ((smi_req && !prev_smi) || (rst_req && !prev_rst)) begin
                int kind;
                kind = rst_req ? 2 : 1;
                if (rst_req) rst_rises++;
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R9/R11 unexpected event kind=%0d at %0d expected none", kind, cyc);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    check("R7 event kind", kind, e.kind);
                    check("R1 event cycle", cyc, e.at);
                end
            end
            smi_w = smi_req ? smi_w + 1 : 0;
            rst_w = rst_req ? rst_w + 1 : 0;
            if (!smi_req && prev_smi) check("R11 smi width", longint'(smi_w_q), 1);
            if (!rst_req && prev_rst) check("R10 reset pulse width", longint'(rst_w_q), PULSE);
            smi_w_q = smi_w; rst_w_q = rst_w;
        end
        prev_smi = smi_req;
        prev_rst = rst_req;
    end
    int smi_w_q = 0, rst_w_q = 0;

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > LIMIT) begin
            checks++; failures++;
            $display("FAIL watchdog timeout actual=%0d expected<%0d", cyc, LIMIT);
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        longint base, base2;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // Reset state
        rd(3'd4, v); check("R5 R9 control reset", v, 16'h0801);
        rd(3'd3, v); check("R8 boot flag reset", v, 16'h0004);
        rd(3'd5, v); check("R11 smi enable reset", v, 16'h0000);
        check("R10 rst_req idle", rst_req, 0);

        // Initial value register
        wr(3'd1, 16'hA805, 2'b11); rd(3'd1, v); check("R2 init full write", v, 16'hA805);
        wr(3'd1, 16'h5403, 2'b11); rd(3'd1, v); check("R3 invalid init ignored", v, 16'hA805);
        wr(3'd1, 16'h0002, 2'b01); rd(3'd1, v); check("R3 invalid byte write ignored", v, 16'hA805);
        wr(3'd1, 16'hFF07, 2'b01); rd(3'd1, v); check("R2 low byte only", v, 16'hA807);

        // Reload and halt
        wr(3'd0, 16'h0000, 2'b11); rd(3'd0, v); check("R4 reload forces count", v, 7);
        repeat (40) @(negedge clk);
        rd(3'd0, v); check("R5 halted count stable", v, 7);

        // Run A: gate closed, SMI disabled: no events
        wr(3'd4, 16'h0001, 2'b11); base = last_edge;
        wait_until(base + 30);
        rd(3'd2, v); check("R6 first expiry flag", v, 16'h0008);
        rd(3'd3, v); check("R7 no second stage yet", v, 16'h0004);
        wait_until(base + 60);
        rd(3'd3, v); check("R7 second stage flag", v, 16'h0006);
        check("R9 gate blocked reset", rst_rises, 0);
        wr(3'd4, 16'h0801, 2'b11);
        rd(3'd4, v); check("R9 gate readback", v, 16'h0801);
        wr(3'd2, 16'h0000, 2'b11); rd(3'd2, v); check("R6 write zero keeps flag", v, 16'h0008);
        wr(3'd2, 16'h0008, 2'b11); rd(3'd2, v); check("R6 write one clears", v, 16'h0000);
        wr(3'd3, 16'h0006, 2'b11); rd(3'd3, v); check("R8 stat2 cleared", v, 16'h0000);

        // Run B: gate open, SMI enabled: SMI then reset
        wr(3'd5, 16'h2000, 2'b11); rd(3'd5, v); check("R11 smi enable readback", v, 16'h2000);
        wr(3'd0, 16'h0000, 2'b11);
        wr(3'd4, 16'h0000, 2'b11); base = last_edge;
        push(1, base + 28); push(2, base + 56);
        wait_until(base + 8);
        rd(3'd0, v); check("R4 count decrements", v, 5);
        rd(3'd4, v); check("R9 gate clear readback", v, 16'h0000);
        wait_until(base + 64);
        rd(3'd3, v); check("R7 second stage after reset", v, 16'h0002);
        wr(3'd4, 16'h0800, 2'b11);
        rd(3'd0, v);
        repeat (20) @(negedge clk);
        begin
            logic [15:0] v2;
            rd(3'd0, v2); check("R5 halt freezes mid-run", v2, v);
        end
        wr(3'd2, 16'h0008, 2'b01); wr(3'd3, 16'h0002, 2'b01);

        // Run C: service after first stage restarts the sequence
        wr(3'd0, 16'h0000, 2'b11);
        wr(3'd4, 16'h0000, 2'b11); base = last_edge;
        push(1, base + 28);
        wait_until(base + 30);
        wr(3'd2, 16'h0008, 2'b01);
        wr(3'd0, 16'h0000, 2'b11); base2 = last_edge;
        push(1, base2 + 28);
        wait_until(base2 + 40);
        wr(3'd4, 16'h0800, 2'b11);
        rd(3'd3, v); check("R7 serviced no second stage", v, 16'h0000);
        check("R1 all expected events seen", exp_q.size(), 0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule